// File: doc/BRIEF.md
# E1 Receive Data-Link Bit Extractor

The extractor sits beside the receive framer of an E1 line interface. It receives the line-decoded bit stream, already aligned to the recovered receive clock, and presents every bit unchanged on a serial data output at the full 2.048 Mb/s rate. With the data it drives a strobe that marks only those national-bit cells of timeslot zero that software has assigned to a data link. An external link controller can then clock the data-link bits straight off the data pin. This path bypasses the receive slip buffer, so a frame slip on the buffered side can neither drop nor repeat a data-link bit.

The recovered clock reaches the block as two single-cycle enables in the system clock domain. The falling-edge enable starts a bit cell and the rising-edge enable marks the middle of that cell. The framer supplies the timeslot, bit and frame position of the arriving bit, together with a loss-of-alignment flag. A five-bit select register picks the national bits. A mode input chooses between a clock-style strobe, which rises at mid cell and falls at the end of the cell, and an enable-style strobe, which covers the whole cell.

The strobe comes from a four-state machine. IDLE: no strobe. ARM: a selected cell in clock mode, before mid cell. PULSE: clock-mode strobe high. WIDE: enable-mode strobe high. On every falling-edge enable, each state moves to WIDE (selected cell, enable mode), to ARM (selected cell, clock mode) or to IDLE (cell not selected). ARM moves to PULSE on the rising-edge enable. In all other cycles every state holds.

Top module: `e1dl_rx_extract`

## Requirements
- R1: On the cycle after a falling-edge enable, `dl_data` equals the `rx_in` value sampled with that enable. It does not change at any other time.
- R2: A cell is marked only when `ts_pos` is 0 at its falling-edge enable.
- R3: Select bit k (`sa_sel[k]`, k = 0..4) marks national bit Sa(4+k), which is the cell with `bit_pos` = 3+k. Bit position 0 is the first bit of the timeslot on the line. A cell whose select bit is clear is not marked.
- R4: In clock mode (`strb_is_enable` = 0), the strobe of a marked cell is low after the falling-edge enable. It goes high on the cycle after the rising-edge enable and returns low after the next falling-edge enable.
- R5: In enable mode (`strb_is_enable` = 1), the strobe is high from the cycle after the falling-edge enable of a marked cell until the next falling-edge enable.
- R6: A cell whose falling-edge enable arrives while `frame_lost` = 1 is not marked.
- R7: After reset, `dl_data` = 0 and `dl_strb` = 0.
- R8: Only frames without the alignment word are eligible, that is frames with `frm_pos[0]` = 1. Cells in even frames are never marked.
- R9: The number of marked cells over a multiframe is 8 × popcount(`sa_sel`), whatever slips occur in the buffered receive path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_fall_en | input | 1 | Recovered clock falling edge (start of bit cell) |
| rx_rise_en | input | 1 | Recovered clock rising edge (middle of bit cell) |
| rx_in | input | 1 | Decoded receive bit, valid with rx_fall_en |
| ts_pos | input | TS_W | Timeslot of the arriving bit |
| bit_pos | input | BIT_W | Bit index within the timeslot, 0 first |
| frm_pos | input | FRM_W | Frame number within the multiframe |
| sa_sel | input | SA_N | National-bit select, bit k selects Sa(4+k) |
| strb_is_enable | input | 1 | 1: enable-style strobe, 0: clock-style strobe |
| frame_lost | input | 1 | Receive framer reports loss of basic alignment |
| dl_data | output | 1 | Serial receive data |
| dl_strb | output | 1 | Data-link strobe |

## Verification
The bench builds the block with its default widths: a 5-bit timeslot, a 3-bit bit index, a 4-bit frame counter and five selectable national bits starting at bit index 3. With these defaults the bench can walk full 16-frame multiframes and reach every national-bit position on its own, as well as the first bit of timeslot 1 right after them. Each bit cell lasts 16 system clocks, with the mid-cell enable eight cycles after the cell start, so the bench can observe the clock-style strobe both low and high within one cell. A slip is applied to a bench-side buffered copy of the stream, and the marked-cell count on the unbuffered output must not change.

// File: rtl/e1dl_pkg.sv
package e1dl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_PULSE = 2'd2,
        ST_WIDE  = 2'd3
    } e1dl_state_t;
endpackage

// File: rtl/e1dl_cell_qual.sv
module e1dl_cell_qual #(
    parameter int TS_W     = 5,
    parameter int BIT_W    = 3,
    parameter int FRM_W    = 4,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic [TS_W-1:0]  ts_pos,
    input  logic [BIT_W-1:0] bit_pos,
    input  logic [FRM_W-1:0] frm_pos,
    input  logic [SA_N-1:0]  sa_sel,
    input  logic             frame_lost,
    output logic             cell_marked
);
    logic [SA_N-1:0] hit;

    // one comparator per national bit
    for (genvar k = 0; k < SA_N; k++) begin : g_sa
        localparam logic [BIT_W-1:0] POS = BIT_W'(SA_FIRST + k);
        assign hit[k] = sa_sel[k] && (bit_pos == POS);
    end

    always_comb begin
        cell_marked = (|hit) && (ts_pos == '0) && frm_pos[0] && !frame_lost;
    end
endmodule

// File: rtl/e1dl_data_retime.sv
module e1dl_data_retime (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_fall_en,
    input  logic rx_in,
    output logic dl_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_data <= 1'b0;
        end else if (rx_fall_en) begin
            dl_data <= rx_in;
        end
    end
endmodule

// File: rtl/e1dl_strobe_fsm.sv
module e1dl_strobe_fsm
    import e1dl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_fall_en,
    input  logic rx_rise_en,
    input  logic cell_marked,
    input  logic strb_is_enable,
    output logic dl_strb
);
    e1dl_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        if (rx_fall_en) begin
            if (!cell_marked) begin
                state_nx = ST_IDLE;
            end else if (strb_is_enable) begin
                state_nx = ST_WIDE;
            end else begin
                state_nx = ST_ARM;
            end
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_ARM:   state_nx = rx_rise_en ? ST_PULSE : ST_ARM;
                ST_PULSE: state_nx = ST_PULSE;
                ST_WIDE:  state_nx = ST_WIDE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        unique case (state)
            ST_PULSE, ST_WIDE: dl_strb = 1'b1;
            default:           dl_strb = 1'b0;
        endcase
    end
endmodule

// File: rtl/e1dl_rx_extract.sv
module e1dl_rx_extract #(
    parameter int TS_W     = 5,
    parameter int BIT_W    = 3,
    parameter int FRM_W    = 4,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_fall_en,
    input  logic             rx_rise_en,
    input  logic             rx_in,
    input  logic [TS_W-1:0]  ts_pos,
    input  logic [BIT_W-1:0] bit_pos,
    input  logic [FRM_W-1:0] frm_pos,
    input  logic [SA_N-1:0]  sa_sel,
    input  logic             strb_is_enable,
    input  logic             frame_lost,
    output logic             dl_data,
    output logic             dl_strb
);
    logic cell_marked;

    e1dl_cell_qual #(
        .TS_W(TS_W), .BIT_W(BIT_W), .FRM_W(FRM_W),
        .SA_N(SA_N), .SA_FIRST(SA_FIRST)
    ) u_qual (
        .ts_pos      (ts_pos),
        .bit_pos     (bit_pos),
        .frm_pos     (frm_pos),
        .sa_sel      (sa_sel),
        .frame_lost  (frame_lost),
        .cell_marked (cell_marked)
    );

    e1dl_data_retime u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_fall_en (rx_fall_en),
        .rx_in      (rx_in),
        .dl_data    (dl_data)
    );

    e1dl_strobe_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rx_fall_en     (rx_fall_en),
        .rx_rise_en     (rx_rise_en),
        .cell_marked    (cell_marked),
        .strb_is_enable (strb_is_enable),
        .dl_strb        (dl_strb)
    );
endmodule

// File: rtl/e1dl_rx_extract_chk.sv
module e1dl_rx_extract_chk #(
    parameter int TS_W  = 5,
    parameter int FRM_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            rx_fall_en,
    input logic            rx_rise_en,
    input logic            rx_in,
    input logic [TS_W-1:0] ts_pos,
    input logic [FRM_W-1:0] frm_pos,
    input logic            strb_is_enable,
    input logic            frame_lost,
    input logic            dl_data,
    input logic            dl_strb
);
    a_r1_data_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fall_en |=> (dl_data == $past(rx_in)));

    a_r1_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_fall_en |=> $stable(dl_data));

    a_r2_ts0_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fall_en && ts_pos != '0) |=> !dl_strb);

    a_r8_odd_frame_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fall_en && !frm_pos[0]) |=> !dl_strb);

    a_r6_lost_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fall_en && frame_lost) |=> !dl_strb);

    a_r4_low_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_fall_en && !strb_is_enable) |=> !dl_strb);

    a_r4_rise_at_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_is_enable && !rx_fall_en && !rx_rise_en) |=> !$rose(dl_strb));
endmodule

bind e1dl_rx_extract e1dl_rx_extract_chk #(.TS_W(TS_W), .FRM_W(FRM_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_fall_en     (rx_fall_en),
    .rx_rise_en     (rx_rise_en),
    .rx_in          (rx_in),
    .ts_pos         (ts_pos),
    .frm_pos        (frm_pos),
    .strb_is_enable (strb_is_enable),
    .frame_lost     (frame_lost),
    .dl_data        (dl_data),
    .dl_strb        (dl_strb)
);

// File: tb/e1dl_rx_extract_test.sv
module e1dl_rx_extract_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_fall_en = 1'b0;
    logic       rx_rise_en = 1'b0;
    logic       rx_in = 1'b0;
    logic [4:0] ts_pos = '0;
    logic [2:0] bit_pos = '0;
    logic [3:0] frm_pos = '0;
    logic [4:0] sa_sel = '0;
    logic       strb_is_enable = 1'b0;
    logic       frame_lost = 1'b0;
    logic       dl_data;
    logic       dl_strb;

    int n_chk = 0;
    int n_bad = 0;
    int marked_cnt = 0;
    bit done = 0;

    typedef struct packed {
        logic d;
        logic mark;
        logic ena;
    } exp_t;
    exp_t sb[$];
    event cell_ev;

    always #5 clk = ~clk;

    e1dl_rx_extract uut (
        .clk(clk), .rst_n(rst_n), .rx_fall_en(rx_fall_en), .rx_rise_en(rx_rise_en),
        .rx_in(rx_in), .ts_pos(ts_pos), .bit_pos(bit_pos), .frm_pos(frm_pos),
        .sa_sel(sa_sel), .strb_is_enable(strb_is_enable), .frame_lost(frame_lost),
        .dl_data(dl_data), .dl_strb(dl_strb)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic expect_mark(input int ts, input int bi, input int fr);
        return (ts == 0) && (fr % 2 == 1) && (bi >= 3) && sa_sel[bi-3] && !frame_lost;
    endfunction

    // driver: one bit cell of 16 system clocks
    task automatic drive_cell(input int ts, input int bi, input int fr, input logic d);
        exp_t e;
        @(negedge clk);
        rx_in = d; ts_pos = 5'(ts); bit_pos = 3'(bi); frm_pos = 4'(fr);
        rx_fall_en = 1'b1;
        e.d = d; e.mark = expect_mark(ts, bi, fr); e.ena = strb_is_enable;
        sb.push_back(e);
        @(negedge clk);
        rx_fall_en = 1'b0;
        ->cell_ev;
        repeat (6) @(negedge clk);
        @(negedge clk);
        rx_rise_en = 1'b1;
        @(negedge clk);
        rx_rise_en = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic drive_frame(input int fr, input int seed);
        for (int b = 0; b < 8; b++) drive_cell(0, b, fr, 1'((seed >> b) ^ fr));
        drive_cell(1, 0, fr, 1'(seed));
        drive_cell(1, 4, fr, 1'(~seed));
    endtask

    // monitor: pops expected items as cells are produced
    initial begin
        forever begin
            exp_t e;
            @(cell_ev);
            e = sb.pop_front();
            check("R1 data after cell start", dl_data, e.d);
            if (e.ena) check("R5 R2 R3 R6 R8 enable strobe early", dl_strb, e.mark);
            else       check("R4 clock strobe low before mid", dl_strb, 1'b0);
            repeat (9) @(negedge clk);
            check("R1 data held", dl_data, e.d);
            check("R2 R3 R4 R5 R6 R8 strobe after mid", dl_strb, e.mark);
            if (dl_strb) marked_cnt++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int buf_cnt;
        repeat (3) @(negedge clk);
        check("R7 reset data", dl_data, 1'b0);
        check("R7 reset strobe", dl_strb, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 idle after reset", dl_strb, 1'b0);

        // R5: enable mode, all national bits
        strb_is_enable = 1'b1; sa_sel = 5'b11111;
        for (int f = 0; f < 4; f++) drive_frame(f, 8'hA5);

        // R4 R3: clock mode, each select bit alone
        strb_is_enable = 1'b0;
        for (int k = 0; k < 5; k++) begin
            sa_sel = 5'(1 << k);
            drive_frame(1, 8'h3C);
            drive_frame(2, 8'h3C);
        end

        // R6: loss of alignment
        sa_sel = 5'b11111; frame_lost = 1'b1;
        drive_frame(3, 8'h5A);
        frame_lost = 1'b0;
        drive_frame(3, 8'h5A);

        // R9: full multiframe, buffered-path slip drops a frame there only
        sa_sel = 5'b01101;
        repeat (20) @(negedge clk);
        marked_cnt = 0;
        buf_cnt = 0;
        for (int f = 0; f < 16; f++) begin
            drive_frame(f, f * 7);
            if (f != 5 && f % 2 == 1) buf_cnt += 3; // slipped copy loses frame 5
        end
        repeat (4) @(negedge clk);
        n_chk++;
        if (marked_cnt != 24) begin
            n_bad++;
            $display("FAIL R9 marked count actual=%0d expected=24 (slipped buffer=%0d)",
                     marked_cnt, buf_cnt);
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule